// File: doc/BRIEF.md
# Dual-Bank Direct-Lookup Input Gamma Table

This block applies an input gamma curve to a stream of three-channel pixels by direct table lookup. Each channel value, cut down to its eight most significant bits, addresses a 256-entry table. Each entry is an unsigned fraction with twelve fractional bits, and the entry read from the table becomes the twelve-bit output for that channel. There are two complete table banks. Each bank holds a separate table for red, green and blue.

A host programs the block through a small write-only register port. It selects the bank that is not in use, sets a start index, and then streams entries through a single data register. The data writes go to red, green and blue in turn, and the index steps forward after every blue write. The host then switches the lookup mode to the bank it has just filled. In this way a new curve takes effect in one step, and pixels never see a table that is only partly written. A status output shows which bank feeds the pixel path, or that the path is bypassed.

Top module: `igam_pingpong_lut`

## Requirements
- R1: After reset the output valid is low, the status is 0 (bypass), the write bank is bank A, the write mask is all ones and the write index is 0 with the sequencer on red.
- R2: The output valid equals the input valid of the previous cycle, and the output data hold their value in cycles that follow an input with valid low.
- R3: In mode code 0 or 1 (bypass), each output channel is the input channel of the previous cycle, zero-extended to 12 bits.
- R4: In mode code 2, each output channel is bank A's entry for that channel, addressed by the top 8 bits of the input channel; the lower input bits are ignored.
- R5: In mode code 3, each output channel is bank B's entry addressed the same way.
- R6: The status output is 1 while the mode is 2, 2 while the mode is 3, and 0 otherwise. It changes in the cycle after the mode write.
- R7: Each data write stores its 12 bits at the current index for the current channel. The channel order is red, green, blue. The index increments after the blue write and wraps from 255 to 0.
- R8: A write to the index register loads the index and restarts the channel order at red, which discards an incomplete triple.
- R9: Write mask bit 0 enables red, bit 1 enables green and bit 2 enables blue. A data write to a masked channel stores nothing, but it still advances the channel order.
- R10: Config bit 0 selects the bank that data writes go to (0 = A, 1 = B). Writing one bank leaves the other bank and the current pixel output unchanged.
- R11: The register map is: address 0 is the mode (wdata[1:0]); address 1 is the config (bit 0 is the bank select, bits 3:1 are the write mask for red, green and blue); address 2 is the index (wdata[7:0]); address 3 is the data (wdata[11:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 12 | Register write data |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_r | input | IN_W | Input red |
| pix_in_g | input | IN_W | Input green |
| pix_in_b | input | IN_W | Input blue |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_r | output | 12 | Output red |
| pix_out_g | output | 12 | Output green |
| pix_out_b | output | 12 | Output blue |
| lut_status | output | 3 | Active-bank status code |

## Verification
The bench uses the default build, with 10-bit input channels, an 8-bit index and 12-bit entries. Because the inputs are wider than the index, two low bits of every channel must be dropped before the lookup, and two zero bits must be added in bypass. Both effects can therefore be observed at the outputs. Both 256-entry banks are filled in full through the data port, and one extra triple forces the index to wrap. The remaining tests exercise masked writes, index restarts and writes into the idle bank while the other bank is live.

// File: rtl/igam_pkg.sv
package igam_pkg;
  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_WCFG  = 2'd1,
    REG_INDEX = 2'd2,
    REG_DATA  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    CH_R = 2'd0,
    CH_G = 2'd1,
    CH_B = 2'd2
  } chan_e;

  localparam int unsigned NUM_CH = 3;
  localparam int unsigned NUM_BANK = 2;

  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_RAM_A  = 2'd2;
  localparam logic [1:0] MODE_RAM_B  = 2'd3;

  localparam logic [2:0] STAT_BYPASS = 3'd0;
  localparam logic [2:0] STAT_RAM_A  = 3'd1;
  localparam logic [2:0] STAT_RAM_B  = 3'd2;
endpackage

// File: rtl/igam_host_seq.sv
module igam_host_seq
  import igam_pkg::*;
#(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned ENTRY_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [ENTRY_W-1:0]   cfg_wdata,
  output logic [1:0]           mode_q,
  output logic [2:0]           status,
  output logic                 wr_bank,
  output logic [NUM_CH-1:0]    wr_strobe,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [ENTRY_W-1:0]   wr_data
);
  logic [1:0]        mode_d;
  logic              sel_q, sel_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  chan_e             phase_q, phase_d;
  logic              data_wr;

  assign data_wr = cfg_we && (reg_addr_e'(cfg_addr) == REG_DATA);

  // next-state
  always_comb begin
    mode_d  = mode_q;
    sel_d   = sel_q;
    mask_d  = mask_q;
    idx_d   = idx_q;
    phase_d = phase_q;
    if (cfg_we) begin
      unique case (reg_addr_e'(cfg_addr))
        REG_MODE:  mode_d = cfg_wdata[1:0];
        REG_WCFG: begin
          sel_d  = cfg_wdata[0];
          mask_d = cfg_wdata[NUM_CH:1];
        end
        REG_INDEX: begin
          idx_d   = cfg_wdata[IDX_W-1:0];
          phase_d = CH_R;
        end
        REG_DATA: begin
          if (phase_q == CH_B) begin
            phase_d = CH_R;
            idx_d   = idx_q + 1'b1;
          end else begin
            phase_d = chan_e'(phase_q + 2'd1);
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_BYPASS;
      sel_q   <= 1'b0;
      mask_q  <= '1;
      idx_q   <= '0;
      phase_q <= CH_R;
    end else if (cfg_we) begin
      mode_q  <= mode_d;
      sel_q   <= sel_d;
      mask_q  <= mask_d;
      idx_q   <= idx_d;
      phase_q <= phase_d;
    end
  end

  always_comb begin
    wr_strobe = '0;
    if (data_wr) wr_strobe[phase_q] = mask_q[phase_q];
  end

  assign wr_bank = sel_q;
  assign wr_idx  = idx_q;
  assign wr_data = cfg_wdata;

  always_comb begin
    unique case (mode_q)
      MODE_RAM_A: status = STAT_RAM_A;
      MODE_RAM_B: status = STAT_RAM_B;
      default:    status = STAT_BYPASS;
    endcase
  end
endmodule

// File: rtl/igam_bank.sv
module igam_bank
  import igam_pkg::*;
#(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned ENTRY_W = 12
) (
  input  logic                             clk,
  input  logic [NUM_CH-1:0]                wr_strobe,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [ENTRY_W-1:0]               wr_data,
  input  logic                             rd_en,
  input  logic [NUM_CH-1:0][IDX_W-1:0]     rd_idx,
  output logic [NUM_CH-1:0][ENTRY_W-1:0]   rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [ENTRY_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_strobe[c]) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[rd_idx[c]];
    end

    assign rd_data[c] = rd_q;
  end
endmodule

// File: rtl/igam_out_stage.sv
module igam_out_stage
  import igam_pkg::*;
#(
  parameter int unsigned IN_W    = 10,
  parameter int unsigned ENTRY_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [NUM_CH-1:0][IN_W-1:0]    in_pix,
  input  logic [1:0]                     mode_q,
  input  logic [NUM_CH-1:0][ENTRY_W-1:0] bank_a,
  input  logic [NUM_CH-1:0][ENTRY_W-1:0] bank_b,
  output logic                           out_valid,
  output logic [NUM_CH-1:0][ENTRY_W-1:0] out_pix
);
  logic                        valid_q;
  logic [1:0]                  mode_p;
  logic [NUM_CH-1:0][IN_W-1:0] byp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_p  <= MODE_BYPASS;
    end else begin
      valid_q <= in_valid;
      if (in_valid) mode_p <= mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) byp_q <= in_pix;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      unique case (mode_p)
        MODE_RAM_A: out_pix[c] = bank_a[c];
        MODE_RAM_B: out_pix[c] = bank_b[c];
        default:    out_pix[c] = ENTRY_W'(byp_q[c]);
      endcase
    end
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/igam_pingpong_lut.sv
module igam_pingpong_lut
  import igam_pkg::*;
#(
  parameter int unsigned IN_W    = 10,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned ENTRY_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  input  logic               pix_in_valid,
  input  logic [IN_W-1:0]    pix_in_r,
  input  logic [IN_W-1:0]    pix_in_g,
  input  logic [IN_W-1:0]    pix_in_b,
  output logic               pix_out_valid,
  output logic [ENTRY_W-1:0] pix_out_r,
  output logic [ENTRY_W-1:0] pix_out_g,
  output logic [ENTRY_W-1:0] pix_out_b,
  output logic [2:0]         lut_status
);
  logic [1:0]                                 mode_q;
  logic                                       wr_bank;
  logic [NUM_CH-1:0]                          wr_strobe;
  logic [IDX_W-1:0]                           wr_idx;
  logic [ENTRY_W-1:0]                         wr_data;
  logic [NUM_CH-1:0][IN_W-1:0]                in_pix;
  logic [NUM_CH-1:0][IDX_W-1:0]               rd_idx;
  logic [NUM_BANK-1:0][NUM_CH-1:0][ENTRY_W-1:0] bank_rd;
  logic [NUM_CH-1:0][ENTRY_W-1:0]             out_pix;

  assign in_pix[CH_R] = pix_in_r;
  assign in_pix[CH_G] = pix_in_g;
  assign in_pix[CH_B] = pix_in_b;

  // keep only the top IDX_W bits of each channel as the table address
  for (genvar c = 0; c < NUM_CH; c++) begin : g_trunc
    assign rd_idx[c] = in_pix[c][IN_W-1 -: IDX_W];
  end

  igam_host_seq #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mode_q(mode_q), .status(lut_status),
    .wr_bank(wr_bank), .wr_strobe(wr_strobe),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [NUM_CH-1:0] bank_strobe;
    assign bank_strobe = (wr_bank == b[0]) ? wr_strobe : '0;

    igam_bank #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_bank (
      .clk(clk),
      .wr_strobe(bank_strobe), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_en(pix_in_valid), .rd_idx(rd_idx),
      .rd_data(bank_rd[b])
    );
  end

  igam_out_stage #(.IN_W(IN_W), .ENTRY_W(ENTRY_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pix_in_valid), .in_pix(in_pix), .mode_q(mode_q),
    .bank_a(bank_rd[0]), .bank_b(bank_rd[1]),
    .out_valid(pix_out_valid), .out_pix(out_pix)
  );

  assign pix_out_r = out_pix[CH_R];
  assign pix_out_g = out_pix[CH_G];
  assign pix_out_b = out_pix[CH_B];
endmodule

// File: rtl/igam_checker.sv
module igam_checker #(
  parameter int unsigned IN_W    = 10,
  parameter int unsigned ENTRY_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [1:0]         cfg_addr,
  input logic [ENTRY_W-1:0] cfg_wdata,
  input logic               pix_in_valid,
  input logic [IN_W-1:0]    pix_in_r,
  input logic [IN_W-1:0]    pix_in_g,
  input logic [IN_W-1:0]    pix_in_b,
  input logic               pix_out_valid,
  input logic [ENTRY_W-1:0] pix_out_r,
  input logic [ENTRY_W-1:0] pix_out_g,
  input logic [ENTRY_W-1:0] pix_out_b,
  input logic [2:0]         lut_status
);
  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (pix_out_valid == $past(pix_in_valid)));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(pix_in_valid)) |->
      ($stable(pix_out_r) && $stable(pix_out_g) && $stable(pix_out_b)));

  p_bypass_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(pix_in_valid) && ($past(lut_status) == 3'd0)) |->
      (pix_out_r == ENTRY_W'($past(pix_in_r)) &&
       pix_out_g == ENTRY_W'($past(pix_in_g)) &&
       pix_out_b == ENTRY_W'($past(pix_in_b))));

  p_status_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lut_status inside {3'd0, 3'd1, 3'd2});

  p_status_rama_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd0 && cfg_wdata[1:0] == 2'd2) |=> (lut_status == 3'd1));

  p_status_ramb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd0 && cfg_wdata[1:0] == 2'd3) |=> (lut_status == 3'd2));

  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !(cfg_we && cfg_addr == 2'd0)) |=> $stable(lut_status));
endmodule

bind igam_pingpong_lut igam_checker #(.IN_W(IN_W), .ENTRY_W(ENTRY_W)) u_chk (.*);

// File: tb/tb_igam_pingpong_lut.sv
`timescale 1ns/1ps
module tb_igam_pingpong_lut;
  localparam int IN_W = 10;
  localparam int EW   = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_addr;
  logic [EW-1:0] cfg_wdata;
  logic pix_in_valid;
  logic [IN_W-1:0] pix_in_r, pix_in_g, pix_in_b;
  logic pix_out_valid;
  logic [EW-1:0] pix_out_r, pix_out_g, pix_out_b;
  logic [2:0] lut_status;

  always #2.5 clk = ~clk;

  igam_pingpong_lut dut (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state, driven purely from the register map
  logic [EW-1:0] mA [3][256];
  logic [EW-1:0] mB [3][256];
  int m_idx = 0, m_ph = 0, m_sel = 0;
  logic [2:0] m_mask = 3'b111;
  logic [1:0] m_mode = 2'd0;

  // {mode[1:0], r[9:0], g[9:0], b[9:0]}
  localparam logic [31:0] VEC [10] = '{
    {2'd0, 10'h3FF, 10'h000, 10'h155},
    {2'd1, 10'h2AA, 10'h001, 10'h3FE},
    {2'd2, 10'h3FF, 10'h3FC, 10'h200},
    {2'd2, 10'h1E7, 10'h0A5, 10'h33C},
    {2'd3, 10'h3FF, 10'h000, 10'h155},
    {2'd3, 10'h004, 10'h3FB, 10'h2A0},
    {2'd0, 10'h2D2, 10'h12C, 10'h001},
    {2'd3, 10'h100, 10'h200, 10'h300},
    {2'd2, 10'h07F, 10'h181, 10'h281},
    {2'd2, 10'h006, 10'h00A, 10'h3F9}
  };

  function automatic logic [EW-1:0] fa(int ch, int i);
    return EW'((i * 13 + ch * 331 + 7) & 12'hFFF);
  endfunction
  function automatic logic [EW-1:0] fb(int ch, int i);
    return EW'((4095 - i * 11 - ch * 97) & 12'hFFF);
  endfunction

  function automatic logic [EW-1:0] expect_ch(logic [1:0] md, int ch, logic [IN_W-1:0] v);
    int ix = int'(v >> 2);
    if (md == 2'd2) return mA[ch][ix];
    if (md == 2'd3) return mB[ch][ix];
    return EW'(v);
  endfunction

  function automatic logic [2:0] expect_stat(logic [1:0] md);
    return (md == 2'd2) ? 3'd1 : (md == 2'd3) ? 3'd2 : 3'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] a, logic [EW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: m_mode = d[1:0];
      2'd1: begin m_sel = int'(d[0]); m_mask = d[3:1]; end
      2'd2: begin m_idx = int'(d[7:0]); m_ph = 0; end
      default: begin
        if (m_mask[m_ph]) begin
          if (m_sel == 0) mA[m_ph][m_idx] = d;
          else            mB[m_ph][m_idx] = d;
        end
        if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
        else m_ph++;
      end
    endcase
  endtask

  // drives one pixel; returns with outputs of that pixel visible
  task automatic send_pix(logic [IN_W-1:0] r, logic [IN_W-1:0] g, logic [IN_W-1:0] b);
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_r = r; pix_in_g = g; pix_in_b = b;
    @(negedge clk);
    pix_in_valid = 1'b0;
  endtask

  task automatic check_pix(string req, logic [IN_W-1:0] r, logic [IN_W-1:0] g, logic [IN_W-1:0] b);
    send_pix(r, g, b);
    check(req, {31'd0, pix_out_valid}, 32'd1);
    check(req, {20'd0, pix_out_r}, {20'd0, expect_ch(m_mode, 0, r)});
    check(req, {20'd0, pix_out_g}, {20'd0, expect_ch(m_mode, 1, g)});
    check(req, {20'd0, pix_out_b}, {20'd0, expect_ch(m_mode, 2, b)});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pix_in_valid = 1'b0; pix_in_r = '0; pix_in_g = '0; pix_in_b = '0;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 valid", {31'd0, pix_out_valid}, 32'd0);
    check("R1 status", {29'd0, lut_status}, 32'd0);
    rst_n = 1'b1;

    // R1: default bank A, mask all ones, index 0 from red
    cfg_write(2'd3, 12'h111);
    cfg_write(2'd3, 12'h222);
    cfg_write(2'd3, 12'h333);
    cfg_write(2'd0, 12'h002);
    check("R1 status", {29'd0, lut_status}, 32'd1);
    check_pix("R1 defaults", 10'h003, 10'h001, 10'h002);

    // R7 R11: fill bank A completely, then one triple past the wrap
    cfg_write(2'd0, 12'h000);
    cfg_write(2'd1, 12'h00E);
    cfg_write(2'd2, 12'h000);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) cfg_write(2'd3, fa(c, i));
    cfg_write(2'd3, 12'h0F1);
    cfg_write(2'd3, 12'h0F2);
    cfg_write(2'd3, 12'h0F3);

    // R10: fill bank B
    cfg_write(2'd1, 12'h00F);
    cfg_write(2'd2, 12'h000);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) cfg_write(2'd3, fb(c, i));

    // table walk: R3 R4 R5 R6
    for (int v = 0; v < 10; v++) begin
      logic [1:0] md = VEC[v][31:30];
      string tag = (md == 2'd2) ? "R4" : (md == 2'd3) ? "R5" : "R3";
      cfg_write(2'd0, {10'd0, md});
      check("R6 status", {29'd0, lut_status}, {29'd0, expect_stat(md)});
      check_pix(tag, VEC[v][29:20], VEC[v][19:10], VEC[v][9:0]);
    end

    // R7: wrapped triple landed in bank A entry 0
    cfg_write(2'd0, 12'h002);
    send_pix(10'h002, 10'h001, 10'h003);
    check("R7 wrap", {20'd0, pix_out_r}, 32'h0F1);
    check("R7 wrap", {20'd0, pix_out_b}, 32'h0F3);

    // R9: red masked in bank B entry 5
    cfg_write(2'd1, 12'h00D);
    cfg_write(2'd2, 12'h005);
    cfg_write(2'd3, 12'hAAA);
    cfg_write(2'd3, 12'hBBB);
    cfg_write(2'd3, 12'hCCC);
    cfg_write(2'd0, 12'h003);
    send_pix(10'h014, 10'h015, 10'h016);
    check("R9 masked red", {20'd0, pix_out_r}, {20'd0, fb(0, 5)});
    check("R9 green", {20'd0, pix_out_g}, 32'hBBB);
    check("R9 blue", {20'd0, pix_out_b}, 32'hCCC);

    // R8: index rewrite discards a partial triple
    cfg_write(2'd1, 12'h00F);
    cfg_write(2'd2, 12'h00A);
    cfg_write(2'd3, 12'h123);
    cfg_write(2'd2, 12'h00A);
    cfg_write(2'd3, 12'h456);
    cfg_write(2'd3, 12'h789);
    cfg_write(2'd3, 12'hABC);
    send_pix(10'h028, 10'h029, 10'h02B);
    check("R8 restart r", {20'd0, pix_out_r}, 32'h456);
    check("R8 restart b", {20'd0, pix_out_b}, 32'hABC);

    // R10: write idle bank B while bank A is live
    cfg_write(2'd0, 12'h002);
    cfg_write(2'd2, 12'h014);
    cfg_write(2'd3, 12'h5A5);
    cfg_write(2'd3, 12'h6B6);
    cfg_write(2'd3, 12'h7C7);
    check_pix("R10 live A", 10'h050, 10'h051, 10'h052);
    cfg_write(2'd0, 12'h003);
    send_pix(10'h050, 10'h051, 10'h052);
    check("R10 new B", {20'd0, pix_out_g}, 32'h6B6);

    // R2: valid drops one cycle after input valid drops, data hold
    @(negedge clk);
    check("R2 valid low", {31'd0, pix_out_valid}, 32'd0);
    check("R2 hold", {20'd0, pix_out_g}, 32'h6B6);

    // R1: reset again returns status to bypass
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rereset", {29'd0, lut_status}, 32'd0);
    rst_n = 1'b1;
    finish_run();
  end
endmodule